// File: doc/BRIEF.md
# Dual-Size Segment Lookaside Buffer

This block holds a small, fully associative set of segment translations. Each slot pairs an effective segment identifier with a 64-bit virtual segment descriptor. A segment spans either 256 MB, with a 28-bit offset, or 1 TB, with a 40-bit offset. Software installs an entry through a single write port. That port presents a tag word and a descriptor word together. The port checks both words in the same cycle and raises an error flag when it refuses them. A refused write leaves the contents untouched.

The lookup port is purely combinational. It takes a 64-bit effective address and returns a hit flag, the slot that matched and that slot's descriptor. Inside each stored tag, the entry keeps a private copy of its two-bit size code in the two lowest bits. The address is turned into two candidate tags, one masked at each segment size, and every slot is compared against both. When several slots match, the lowest-numbered one is reported.

A readback port shows the tag and descriptor of any slot, with the private size-code copy masked off. A single-cycle invalidate-all input clears every valid bit.

Top module: `seg_lookaside`

## Requirements
- R1: A synchronous active-low reset clears every slot. Afterwards every lookup misses, and readback returns zero for both the tag and the descriptor of every slot.
- R2: An accepted write to slot s behaves as follows. The slot number s is `wr_tag[11:0]`. The slot keeps `wr_tag[63:28]` as the segment identifier and `wr_tag[27]` as its valid bit, and bits 26:0 of the tag word are dropped. The descriptor is kept unchanged. Readback of slot s then returns the tag word with bits 26:0 cleared.
- R3: A write is refused (`wr_err`=1 in the cycle `wr_en` is high) when any bit of `wr_tag[11:0]` at or above bit position log2(SLOTS) is set. A refused write changes no slot.
- R4: The segment-size code is `wr_desc[63:62]`: 00 selects 256 MB and 01 selects 1 TB. A write with `wr_desc[63]`=1 is refused and changes no slot.
- R5: When the parameter LARGE_SEG_EN is 0, a write with `wr_desc[62]`=1 is refused.
- R6: A valid slot with size code 00 hits when `lk_ea[63:28]` equals its stored `tag[63:28]`. A slot whose valid bit is 0 never hits.
- R7: A valid slot with size code 01 hits when `lk_ea[63:40]` equals its stored `tag[63:40]` and its stored `tag[39:28]` is zero. `lk_ea[39:0]` does not matter. A 1 TB entry is never matched at 256 MB granularity, and a 256 MB entry is never matched at 1 TB granularity.
- R8: When more than one slot hits, `lk_slot` and `lk_desc` report the lowest-numbered hitting slot.
- R9: On a miss, `lk_hit`, `lk_slot` and `lk_desc` are all zero.
- R10: A cycle with `inval_all`=1 clears the valid bit of every slot and keeps the rest of each tag. An accepted write in the same cycle is applied after the clear, so its slot stays valid.
- R11: Readback tag bits 1:0 are always zero, even for a 1 TB entry. The readback descriptor returns the full stored word, including the size code.
- R12: `wr_err` is combinational from the write inputs, and it is 0 whenever `wr_en` is 0, whatever the words carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes, invalidation and reset act on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| inval_all | input | 1 | Clears all valid bits at the next edge |
| wr_en | input | 1 | Write request |
| wr_tag | input | 64 | Segment identifier [63:28], valid [27], slot number [11:0] |
| wr_desc | input | 64 | Descriptor word, size code in [63:62] |
| wr_err | output | 1 | Write refused (same cycle as wr_en) |
| lk_ea | input | 64 | Effective address to translate |
| lk_hit | output | 1 | Some slot matched |
| lk_slot | output | log2(SLOTS) | Lowest matching slot, zero on miss |
| lk_desc | output | 64 | Descriptor of the matching slot, zero on miss |
| rd_slot | input | log2(SLOTS) | Slot to read back |
| rd_tag | output | 64 | Stored tag of rd_slot with bits 1:0 cleared |
| rd_desc | output | 64 | Stored descriptor of rd_slot |

## Verification
Lookups cover several address patterns. Addresses with noise in the offset bits show that only the segment bits are compared. Addresses one segment past a stored entry show where a segment ends. A 256 MB entry whose identifier also looks 1 TB aligned is probed at both granularities, which separates a correct size-code compare from one that ignores the code; a 1 TB entry carrying stray bits 39:28 tells the same apart from the other side. Duplicate segments installed out of slot order separate lowest-slot priority from last-written or highest-slot priority. Refused writes aimed at an occupied slot separate "refused and ignored" from "flagged but stored". A second instance built without 1 TB support and with fewer slots covers the build-time variant.

// File: rtl/seg_lookaside_pkg.sv
// Shared constants, types and candidate-tag builder for the segment
// lookaside buffer. Assumes 64-bit tag and descriptor words.
package seg_lookaside_pkg;

    localparam int WORD_W       = 64;
    localparam int SLOT_FIELD_W = 12;   // slot number field in the tag word
    localparam int SMALL_OFS_W  = 28;   // 256 MB segment offset width
    localparam int LARGE_OFS_W  = 40;   // 1 TB segment offset width
    localparam int VALID_POS    = 27;   // valid bit position in a tag

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        SEG_256M = 2'b00,
        SEG_1T   = 2'b01
    } seg_size_e;

    // Bits of a written tag word that survive into storage: id plus valid.
    localparam word_t TAG_KEEP = {{(WORD_W-SMALL_OFS_W){1'b1}}, 1'b1,
                                  {(SMALL_OFS_W-1){1'b0}}};

    // Build a lookup candidate: address masked to the segment boundary,
    // valid set, size code in the two low bits.
    function automatic word_t make_cand(word_t ea, int ofs_w, seg_size_e sz);
        word_t seg_mask;
        seg_mask = ~((word_t'(1) << ofs_w) - word_t'(1));
        return (ea & seg_mask) | (word_t'(1) << VALID_POS) | word_t'(sz);
    endfunction

endpackage

// File: rtl/seg_wr_check.sv
// Write-word checker: decides whether a write is accepted and forms the
// tag value to store. Purely combinational.
// Assumes SLOTS is a power of two no larger than 4096.
module seg_wr_check
    import seg_lookaside_pkg::*;
#(
    parameter int SLOTS        = 64,
    parameter bit LARGE_SEG_EN = 1'b1,
    localparam int IDX_W       = $clog2(SLOTS)
) (
    input  logic             wr_en,
    input  word_t            wr_tag,
    input  logic [1:0]       wr_size,
    output logic             wr_ok,
    output logic             wr_err,
    output logic [IDX_W-1:0] wr_slot,
    output word_t            stored_tag
);

    // Slot-field bits that must be zero: reserved bits and out-of-range slots.
    localparam logic [SLOT_FIELD_W-1:0] SLOT_REJECT =
        SLOT_FIELD_W'((1 << SLOT_FIELD_W) - SLOTS);

    logic slot_bad;
    logic size_bad;
    logic large_bad;
    logic refuse;

    // Classify the write words against the three refusal rules.
    always_comb begin
        slot_bad  = |(wr_tag[SLOT_FIELD_W-1:0] & SLOT_REJECT);
        size_bad  = wr_size[1];
        large_bad = !LARGE_SEG_EN && wr_size[0];
        refuse    = slot_bad || size_bad || large_bad;
    end

    // Qualify accept/refuse with the write strobe.
    always_comb begin
        wr_ok  = wr_en && !refuse;
        wr_err = wr_en && refuse;
    end

    // Form slot index and the tag with the size code folded into bits 1:0.
    always_comb begin
        wr_slot    = wr_tag[IDX_W-1:0];
        stored_tag = (wr_tag & TAG_KEEP) | word_t'(wr_size);
    end

endmodule

// File: rtl/seg_entry_store.sv
// Slot storage: one tag and one descriptor register per slot.
// Reset zeroes everything; invalidate-all clears valid bits; an accepted
// write overrides the invalidate for its own slot.
module seg_entry_store
    import seg_lookaside_pkg::*;
#(
    parameter int SLOTS  = 64,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    inval_all,
    input  logic                    wr_ok,
    input  logic [IDX_W-1:0]        wr_slot,
    input  word_t                   wr_tag_val,
    input  word_t                   wr_desc_val,
    output logic [SLOTS-1:0][WORD_W-1:0] tag_q,
    output logic [SLOTS-1:0][WORD_W-1:0] desc_q
);

    logic [SLOTS-1:0] valid_vec;

    // Per-slot update: reset, then write-over-invalidate priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '0;
            desc_q <= '0;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (wr_ok && (wr_slot == IDX_W'(i))) begin
                    tag_q[i]  <= wr_tag_val;
                    desc_q[i] <= wr_desc_val;
                end else if (inval_all) begin
                    tag_q[i][VALID_POS] <= 1'b0;
                end
            end
        end
    end

    // Gather valid bits for the checks below.
    for (genvar g = 0; g < SLOTS; g++) begin : g_valid
        assign valid_vec[g] = tag_q[g][VALID_POS];
    end

    AST_INVAL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (inval_all && !wr_ok) |=> (valid_vec == '0)); // R10

    AST_REFUSED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ok && !inval_all) |=> ($stable(tag_q) && $stable(desc_q))); // R3

endmodule

// File: rtl/seg_match_select.sv
// Lookup path: builds the 256 MB and 1 TB candidates from the address,
// compares every slot against both, and picks the lowest hitting slot.
// Purely combinational.
module seg_match_select
    import seg_lookaside_pkg::*;
#(
    parameter int SLOTS  = 64,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  word_t                        lk_ea,
    input  logic [SLOTS-1:0][WORD_W-1:0] tag_q,
    input  logic [SLOTS-1:0][WORD_W-1:0] desc_q,
    output logic [SLOTS-1:0]             match_vec,
    output logic                         hit,
    output logic [IDX_W-1:0]             hit_slot,
    output word_t                        hit_desc
);

    word_t cand_small;
    word_t cand_large;

    // Form both candidate tags from the effective address.
    always_comb begin
        cand_small = make_cand(lk_ea, SMALL_OFS_W, SEG_256M);
        cand_large = make_cand(lk_ea, LARGE_OFS_W, SEG_1T);
    end

    // One dual comparator per slot.
    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign match_vec[g] = (tag_q[g] == cand_small) || (tag_q[g] == cand_large);
    end

    // Priority pick: scanning downward leaves the lowest match.
    always_comb begin
        hit_slot = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (match_vec[i]) hit_slot = IDX_W'(i);
        end
        hit = |match_vec;
    end

    // Return the selected descriptor, zero on a miss.
    always_comb begin
        hit_desc = hit ? desc_q[hit_slot] : '0;
    end

endmodule

// File: rtl/seg_lookaside.sv
// Top of the dual-size segment lookaside buffer. Ties together the write
// checker, slot storage and lookup selector; drives the readback port.
// Assumes SLOTS is a power of two between 2 and 4096.
module seg_lookaside
    import seg_lookaside_pkg::*;
#(
    parameter int SLOTS        = 64,
    parameter bit LARGE_SEG_EN = 1'b1,
    localparam int IDX_W       = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inval_all,
    input  logic             wr_en,
    input  logic [63:0]      wr_tag,
    input  logic [63:0]      wr_desc,
    output logic             wr_err,
    input  logic [63:0]      lk_ea,
    output logic             lk_hit,
    output logic [IDX_W-1:0] lk_slot,
    output logic [63:0]      lk_desc,
    input  logic [IDX_W-1:0] rd_slot,
    output logic [63:0]      rd_tag,
    output logic [63:0]      rd_desc
);

    localparam logic [SLOT_FIELD_W-1:0] SLOT_REJECT =
        SLOT_FIELD_W'((1 << SLOT_FIELD_W) - SLOTS);

    logic                         wr_ok;
    logic [IDX_W-1:0]             wr_slot;
    word_t                        stored_tag;
    logic [SLOTS-1:0][WORD_W-1:0] tag_q;
    logic [SLOTS-1:0][WORD_W-1:0] desc_q;
    logic [SLOTS-1:0]             match_vec;

    seg_wr_check #(
        .SLOTS        (SLOTS),
        .LARGE_SEG_EN (LARGE_SEG_EN)
    ) chk_i (
        .wr_en      (wr_en),
        .wr_tag     (wr_tag),
        .wr_size    (wr_desc[63:62]),
        .wr_ok      (wr_ok),
        .wr_err     (wr_err),
        .wr_slot    (wr_slot),
        .stored_tag (stored_tag)
    );

    seg_entry_store #(
        .SLOTS (SLOTS)
    ) store_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .inval_all   (inval_all),
        .wr_ok       (wr_ok),
        .wr_slot     (wr_slot),
        .wr_tag_val  (stored_tag),
        .wr_desc_val (wr_desc),
        .tag_q       (tag_q),
        .desc_q      (desc_q)
    );

    seg_match_select #(
        .SLOTS (SLOTS)
    ) sel_i (
        .lk_ea     (lk_ea),
        .tag_q     (tag_q),
        .desc_q    (desc_q),
        .match_vec (match_vec),
        .hit       (lk_hit),
        .hit_slot  (lk_slot),
        .hit_desc  (lk_desc)
    );

    // Readback: hide the internal size-code copy in tag bits 1:0.
    always_comb begin
        rd_tag  = tag_q[rd_slot] & ~word_t'(3);
        rd_desc = desc_q[rd_slot];
    end

    AST_SIZE_HI_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_desc[63]) |-> wr_err); // R4

    AST_SLOT_RANGE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((wr_tag[SLOT_FIELD_W-1:0] & SLOT_REJECT) != '0)) |-> wr_err); // R3

    AST_LARGE_OFF_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!LARGE_SEG_EN && wr_en && wr_desc[62]) |-> wr_err); // R5

    AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> !wr_err); // R12

    AST_ACCEPT_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_err) |=> (tag_q[$past(wr_tag[IDX_W-1:0])][63:27] == $past(wr_tag[63:27]))); // R2

    AST_HIT_TAG_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (tag_q[lk_slot][VALID_POS] &&
                    (((tag_q[lk_slot][1:0] == 2'b00) && (tag_q[lk_slot][63:28] == lk_ea[63:28])) ||
                     ((tag_q[lk_slot][1:0] == 2'b01) && (tag_q[lk_slot][63:40] == lk_ea[63:40]))))); // R6

    AST_HIT_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (match_vec[lk_slot] &&
                    ((match_vec & ((SLOTS'(1) << lk_slot) - SLOTS'(1))) == '0))); // R8

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> ((lk_slot == '0) && (lk_desc == '0))); // R9

endmodule

// File: tb/seg_lookaside_tb_top.sv
`timescale 1ns/1ps
module seg_lookaside_tb_top;

    localparam int SLOTS   = 64;
    localparam int IDX_W   = 6;
    localparam int S_SLOTS = 16;
    localparam int S_IDX_W = 4;

    localparam logic [1:0] OP_W = 2'd0;
    localparam logic [1:0] OP_L = 2'd1;
    localparam logic [1:0] OP_R = 2'd2;

    typedef struct packed {
        logic [1:0]  op;    // write / lookup / readback
        logic [63:0] a;     // tag word, address, or unused
        logic [63:0] b;     // descriptor, or expected readback descriptor
        logic        flag;  // expected wr_err or lk_hit
        logic [5:0]  slot;  // expected hit slot, or slot to read
        logic [63:0] data;  // expected lk_desc or readback tag
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t TBL [NV] = '{
        '{OP_W, 64'h0000_0012_3800_0003, 64'h0000_0000_00AB_C000, 1'b0, 6'd0,  64'h0, 4'd2},  // R2
        '{OP_L, 64'h0000_0012_3456_789A, 64'h0, 1'b1, 6'd3,  64'h0000_0000_00AB_C000, 4'd6},  // R6
        '{OP_L, 64'h0000_0012_4000_0000, 64'h0, 1'b0, 6'd0,  64'h0, 4'd9},                    // R9
        '{OP_W, 64'h0000_AB00_0800_0005, 64'h4000_0000_0123_4000, 1'b0, 6'd0,  64'h0, 4'd7},  // R7
        '{OP_L, 64'h0000_ABFF_FFFF_1234, 64'h0, 1'b1, 6'd5,  64'h4000_0000_0123_4000, 4'd7},  // R7
        '{OP_L, 64'h0000_AC00_0000_0000, 64'h0, 1'b0, 6'd0,  64'h0, 4'd7},                    // R7
        '{OP_W, 64'h0000_0012_3800_0007, 64'h0000_0000_0077_7000, 1'b0, 6'd0,  64'h0, 4'd8},  // R8
        '{OP_L, 64'h0000_0012_3000_0000, 64'h0, 1'b1, 6'd3,  64'h0000_0000_00AB_C000, 4'd8},  // R8
        '{OP_W, 64'h0000_0012_3800_0001, 64'h0000_0000_0011_1000, 1'b0, 6'd0,  64'h0, 4'd8},  // R8
        '{OP_L, 64'h0000_0012_3FFF_FFFF, 64'h0, 1'b1, 6'd1,  64'h0000_0000_0011_1000, 4'd8},  // R8
        '{OP_W, 64'h0000_0055_5800_0009, 64'h8000_0000_0000_0000, 1'b1, 6'd0,  64'h0, 4'd4},  // R4
        '{OP_W, 64'h0000_0055_5800_0009, 64'hC000_0000_0000_0000, 1'b1, 6'd0,  64'h0, 4'd4},  // R4
        '{OP_L, 64'h0000_0055_5000_0000, 64'h0, 1'b0, 6'd0,  64'h0, 4'd4},                    // R4
        '{OP_W, 64'h0000_0066_6800_0040, 64'h0, 1'b1, 6'd0,  64'h0, 4'd3},                    // R3
        '{OP_W, 64'h0000_0066_6800_0800, 64'h0, 1'b1, 6'd0,  64'h0, 4'd3},                    // R3
        '{OP_L, 64'h0000_0066_6000_0000, 64'h0, 1'b0, 6'd0,  64'h0, 4'd3},                    // R3
        '{OP_W, 64'h0000_0066_6800_0041, 64'h0000_0000_0DEA_D000, 1'b1, 6'd0,  64'h0, 4'd3},  // R3
        '{OP_R, 64'h0, 64'h0000_0000_0011_1000, 1'b0, 6'd1,  64'h0000_0012_3800_0000, 4'd3},  // R3
        '{OP_R, 64'h0, 64'h4000_0000_0123_4000, 1'b0, 6'd5,  64'h0000_AB00_0800_0000, 4'd11}, // R11
        '{OP_W, 64'h0000_0077_7FFF_F00A, 64'h0000_0000_0000_0F00, 1'b0, 6'd0,  64'h0, 4'd2},  // R2
        '{OP_R, 64'h0, 64'h0000_0000_0000_0F00, 1'b0, 6'd10, 64'h0000_0077_7800_0000, 4'd2},  // R2
        '{OP_W, 64'h0000_0088_8000_000C, 64'h0000_0000_0000_5000, 1'b0, 6'd0,  64'h0, 4'd6},  // R6
        '{OP_L, 64'h0000_0088_8000_0000, 64'h0, 1'b0, 6'd0,  64'h0, 4'd6},                    // R6
        '{OP_W, 64'h0000_CD00_0800_0014, 64'h0000_0000_0000_2000, 1'b0, 6'd0,  64'h0, 4'd6},  // R6
        '{OP_L, 64'h0000_CD00_0FFF_FFFF, 64'h0, 1'b1, 6'd20, 64'h0000_0000_0000_2000, 4'd6},  // R6
        '{OP_L, 64'h0000_CD00_1000_0000, 64'h0, 1'b0, 6'd0,  64'h0, 4'd7},                    // R7
        '{OP_W, 64'h0000_EE01_0800_0015, 64'h4000_0000_0000_3000, 1'b0, 6'd0,  64'h0, 4'd7},  // R7
        '{OP_L, 64'h0000_EE01_0000_0000, 64'h0, 1'b0, 6'd0,  64'h0, 4'd7},                    // R7
        '{OP_R, 64'h0, 64'h4000_0000_0000_3000, 1'b0, 6'd21, 64'h0000_EE01_0800_0000, 4'd11}, // R11
        '{OP_R, 64'h0, 64'h0, 1'b0, 6'd63, 64'h0, 4'd1}                                       // R1
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic             inval_all = 1'b0;
    logic             wr_en = 1'b0;
    logic [63:0]      wr_tag = '0;
    logic [63:0]      wr_desc = '0;
    logic             wr_err;
    logic [63:0]      lk_ea = '0;
    logic             lk_hit;
    logic [IDX_W-1:0] lk_slot;
    logic [63:0]      lk_desc;
    logic [IDX_W-1:0] rd_slot = '0;
    logic [63:0]      rd_tag;
    logic [63:0]      rd_desc;

    logic               s_wr_en = 1'b0;
    logic [63:0]        s_wr_tag = '0;
    logic [63:0]        s_wr_desc = '0;
    logic               s_wr_err;
    logic [63:0]        s_lk_ea = '0;
    logic               s_lk_hit;
    logic [S_IDX_W-1:0] s_lk_slot;
    logic [63:0]        s_lk_desc;
    logic [63:0]        s_rd_tag;
    logic [63:0]        s_rd_desc;

    seg_lookaside #(.SLOTS(SLOTS), .LARGE_SEG_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .inval_all(inval_all),
        .wr_en(wr_en), .wr_tag(wr_tag), .wr_desc(wr_desc), .wr_err(wr_err),
        .lk_ea(lk_ea), .lk_hit(lk_hit), .lk_slot(lk_slot), .lk_desc(lk_desc),
        .rd_slot(rd_slot), .rd_tag(rd_tag), .rd_desc(rd_desc)
    );

    seg_lookaside #(.SLOTS(S_SLOTS), .LARGE_SEG_EN(1'b0)) dut_small_i (
        .clk(clk), .rst_n(rst_n), .inval_all(1'b0),
        .wr_en(s_wr_en), .wr_tag(s_wr_tag), .wr_desc(s_wr_desc), .wr_err(s_wr_err),
        .lk_ea(s_lk_ea), .lk_hit(s_lk_hit), .lk_slot(s_lk_slot), .lk_desc(s_lk_desc),
        .rd_slot('0), .rd_tag(s_rd_tag), .rd_desc(s_rd_desc)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic do_write(input logic [63:0] t, input logic [63:0] d,
                            input logic exp_err, input string req);
        @(negedge clk);
        wr_en = 1'b1; wr_tag = t; wr_desc = d;
        #1 chk({req, " wr_err"}, 64'(wr_err), 64'(exp_err));
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic do_lookup(input logic [63:0] ea, input logic exp_hit,
                             input logic [5:0] exp_slot, input logic [63:0] exp_desc,
                             input string req);
        @(negedge clk);
        lk_ea = ea;
        #1;
        chk({req, " lk_hit"}, 64'(lk_hit), 64'(exp_hit));
        chk({req, " lk_slot"}, 64'(lk_slot), 64'(exp_slot));
        chk({req, " lk_desc"}, lk_desc, exp_desc);
    endtask

    task automatic do_read(input logic [5:0] s, input logic [63:0] exp_tag,
                           input logic [63:0] exp_desc, input string req);
        @(negedge clk);
        rd_slot = s;
        #1;
        chk({req, " rd_tag"}, rd_tag, exp_tag);
        chk({req, " rd_desc"}, rd_desc, exp_desc);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: state right after reset
        do_lookup(64'h0, 1'b0, 6'd0, 64'h0, "R1");
        do_read(6'd0, 64'h0, 64'h0, "R1");

        // R12: error flag silent without a write strobe
        @(negedge clk);
        wr_en = 1'b0; wr_tag = 64'hFFFF_FFFF_FFFF_FFFF; wr_desc = 64'hC000_0000_0000_0000;
        #1 chk("R12 wr_err idle", 64'(wr_err), 64'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d", TBL[i].req);
            case (TBL[i].op)
                OP_W:    do_write(TBL[i].a, TBL[i].b, TBL[i].flag, rq);
                OP_L:    do_lookup(TBL[i].a, TBL[i].flag, TBL[i].slot, TBL[i].data, rq);
                default: do_read(TBL[i].slot, TBL[i].data, TBL[i].b, rq);
            endcase
        end

        // R10: invalidate-all clears valid bits, keeps the identifiers
        @(negedge clk) inval_all = 1'b1;
        @(posedge clk);
        #1 inval_all = 1'b0;
        do_lookup(64'h0000_0012_3000_0000, 1'b0, 6'd0, 64'h0, "R10");
        do_read(6'd1, 64'h0000_0012_3000_0000, 64'h0000_0000_0011_1000, "R10");

        // R10: write in the same cycle as invalidate survives
        @(negedge clk);
        inval_all = 1'b1; wr_en = 1'b1;
        wr_tag = 64'h0000_0099_9800_0004; wr_desc = 64'h0000_0000_0000_9000;
        #1 chk("R10 wr_err", 64'(wr_err), 64'h0);
        @(posedge clk);
        #1 begin inval_all = 1'b0; wr_en = 1'b0; end
        do_lookup(64'h0000_0099_9000_0000, 1'b1, 6'd4, 64'h0000_0000_0000_9000, "R10");
        do_lookup(64'h0000_ABFF_0000_0000, 1'b0, 6'd0, 64'h0, "R10");

        // R5: instance without 1 TB support and 16 slots
        @(negedge clk);
        s_wr_en = 1'b1; s_wr_tag = 64'h0000_AB00_0800_0002; s_wr_desc = 64'h4000_0000_0000_1000;
        #1 chk("R5 small wr_err 1T", 64'(s_wr_err), 64'h1);
        @(posedge clk);
        #1 s_wr_en = 1'b0;
        @(negedge clk);
        s_lk_ea = 64'h0000_AB00_0000_0000;
        #1 chk("R5 small lk_hit", 64'(s_lk_hit), 64'h0);
        @(negedge clk);
        s_wr_en = 1'b1; s_wr_tag = 64'h0000_0031_0800_0010; s_wr_desc = 64'h0000_0000_0000_3100;
        #1 chk("R3 small slot 16 wr_err", 64'(s_wr_err), 64'h1);
        @(posedge clk);
        #1 s_wr_en = 1'b0;
        @(negedge clk);
        s_wr_en = 1'b1; s_wr_tag = 64'h0000_0031_0800_0002; s_wr_desc = 64'h0000_0000_0000_3100;
        #1 chk("R5 small wr_err 256M", 64'(s_wr_err), 64'h0);
        @(posedge clk);
        #1 s_wr_en = 1'b0;
        @(negedge clk);
        s_lk_ea = 64'h0000_0031_0000_0000;
        #1;
        chk("R5 small lk_hit", 64'(s_lk_hit), 64'h1);
        chk("R5 small lk_slot", 64'(s_lk_slot), 64'h2);
        chk("R5 small lk_desc", s_lk_desc, 64'h0000_0000_0000_3100);

        // R1: reset in mid-run empties the buffer
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        do_lookup(64'h0000_0099_9000_0000, 1'b0, 6'd0, 64'h0, "R1");
        do_read(6'd4, 64'h0, 64'h0, "R1");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule